// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a 32-bit synchronous static RAM with a four-beat burst address generator. Its depth is set by a parameter and kept small for simulation. At every rising clock edge it samples an address, two address strobes, an advance control, three chip selects and a set of write controls. It decodes the cycle type from these inputs, which gives one of six outcomes: deselect, processor-started read, controller-started access, burst advance, hold, or idle.

Writes store a full word or any subset of the four byte lanes. Read data comes from the array combinationally in flow-through mode, or through an output register one clock later in pipelined mode. An active-low output enable decides whether the data pins are driven.

A separate sequencer produces burst addresses in one of two orders. The linear order increments the two low address bits modulo four. The interleaved order XORs the burst count into the two low address bits. The upper address bits never change within a burst.

Top module: `sync_burst_sram`

## Requirements
- R1: When `cs_strobe_n` is 0 and `sel_a_n` is 1 at an edge, the block is deselected, whatever `ps_strobe_n` is. No read or write is issued, the pins are not driven in the following cycle, and any burst in progress ends, so a later advance does nothing.
- R2: When `sel_a_n` is 0, either strobe is 0, and `sel_c_n` is 1 or `sel_b` is 0, the block is deselected in the same way. No read is issued and no write changes the array.
- R3: When `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0 and `ps_strobe_n`=0, a burst starts at `addr_i` and the access is always a read, even if the write controls are asserted.
- R4: When `ps_strobe_n`=1 and `cs_strobe_n`=0 under a valid select, a burst starts at `addr_i`. The access is a write when `wr_all_n`=0 or `wr_bytes_n`=0, and a read otherwise.
- R5: When `sel_a_n`=1, `ps_strobe_n` is ignored. With `ps_strobe_n`=0, `cs_strobe_n`=1 and `advance_n`=0, the burst continues to the next address.
- R6: With both strobes 1 and `advance_n`=0, an active burst moves to its next beat, and that beat is a read or a write according to the write controls. With `order_lin`=1 the low two bits are base+k mod 4. With `order_lin`=0 they are base XOR k. The upper bits stay fixed and the sequence wraps after the fourth beat.
- R7: With both strobes and `advance_n` all 1, an active burst repeats its current address.
- R8: `dq_drive` is 1 only while a read result is being presented and `out_en_n` is 0. `out_en_n` acts on `dq_drive` within the same cycle, without waiting for a clock edge.
- R9: A write with `wr_all_n`=0 stores all four bytes, whatever `wr_bytes_n` and `lane_n` are.
- R10: With `wr_all_n`=1, byte n (bits 8n+7:8n) is written only when `wr_bytes_n`=0 and `lane_n[n]`=0.
- R11: Write data on `dq_i` is sampled at the edge after the address edge. With `flow_thru`=0, the byte-write controls are also taken at that data edge. With `flow_thru`=1, they are taken at the address edge.
- R12: Read data for an address issued at edge k is on `dq_o` after edge k when `flow_thru`=1, and after edge k+1 when `flow_thru`=0.
- R13: After reset no burst is active and `dq_drive` is 0. An advance issued straight after reset drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr_i | input | ADDR_W | Word address |
| ps_strobe_n | input | 1 | Processor address strobe, active low |
| cs_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Primary chip select, active low |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_bytes_n | input | 1 | Byte-write enable, active low |
| lane_n | input | NB | Per-byte write selects, active low |
| out_en_n | input | 1 | Output enable, active low |
| order_lin | input | 1 | 1 selects linear burst order, 0 interleaved |
| flow_thru | input | 1 | 1 selects flow-through reads, 0 pipelined |
| dq_i | input | NB*8 | Write data |
| dq_o | output | NB*8 | Read data |
| dq_drive | output | 1 | 1 when the data pins are driven; 0 stands for high impedance |

## Verification
The array is first loaded with address-dependent words. A table of write-then-read pairs then exercises whole-word, single-byte, no-byte and non-write controls in both read modes. Some pairs set the byte controls differently in the address cycle and the data cycle, so a design that latches them at the wrong edge stores a different word. Bursts from several start offsets in both orders separate linear from interleaved sequencing, and wrap from no wrap. Each burst is read in both modes, so the one-cycle offset between them shows up. Directed cases drive the strobes under each chip-select combination and show whether the strobe priority and the deselect rules are applied or lost.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Cycle type decoded from the strobes, selects and advance control
  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_DESEL    = 3'd1,
    CYC_START_RD = 3'd2,
    CYC_START_EX = 3'd3,
    CYC_NEXT     = 3'd4,
    CYC_HOLD     = 3'd5
  } cyc_e;

  localparam int unsigned BEAT_W = 2;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic          ps_strobe_n,
  input  logic          cs_strobe_n,
  input  logic          advance_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          wr_all_n,
  input  logic          wr_bytes_n,
  input  logic [NB-1:0] lane_n,
  input  logic          active,
  output cyc_e          cyc,
  output logic          is_wr,
  output logic [NB-1:0] mask
);
  logic sel_ok;
  logic any_strobe;

  assign sel_ok     = !sel_a_n && sel_b && !sel_c_n;
  assign any_strobe = !ps_strobe_n || !cs_strobe_n;

  // Priority order matters: the controller strobe with the primary select
  // negated wins first, then a bad secondary select, then the processor strobe.
  always_comb begin
    if (!cs_strobe_n && sel_a_n) begin
      cyc = CYC_DESEL;
    end else if (!sel_a_n && any_strobe && !(sel_b && !sel_c_n)) begin
      cyc = CYC_DESEL;
    end else if (sel_ok && !ps_strobe_n) begin
      cyc = CYC_START_RD;
    end else if (sel_ok && !cs_strobe_n) begin
      cyc = CYC_START_EX;
    end else if (!advance_n) begin
      cyc = active ? CYC_NEXT : CYC_IDLE;
    end else begin
      cyc = active ? CYC_HOLD : CYC_IDLE;
    end
  end

  assign is_wr = !wr_all_n || !wr_bytes_n;

  always_comb begin
    if (!wr_all_n) begin
      mask = '1;
    end else if (!wr_bytes_n) begin
      mask = ~lane_n;
    end else begin
      mask = '0;
    end
  end
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] addr
);
  logic [BEAT_W-1:0] low;

  assign low = order_lin ? (base[BEAT_W-1:0] + beat) : (base[BEAT_W-1:0] ^ beat);

  generate
    if (ADDR_W > BEAT_W) begin : g_wide
      assign addr = {base[ADDR_W-1:BEAT_W], low};
    end else begin : g_narrow
      assign addr = low;
    end
  endgenerate
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NB     = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [NB-1:0]        lane_we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NB*LANE_W-1:0] wdata,
  output logic [NB*LANE_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [NB*LANE_W-1:0] mem [DEPTH];

  generate
    for (genvar n = 0; n < NB; n++) begin : g_lane
      always_ff @(posedge clk) begin
        if (we && lane_we[n]) begin
          mem[addr][n*LANE_W +: LANE_W] <= wdata[n*LANE_W +: LANE_W];
        end
      end
    end
  endgenerate

  assign rdata = mem[addr];
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NB     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ps_strobe_n,
  input  logic              cs_strobe_n,
  input  logic              advance_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_all_n,
  input  logic              wr_bytes_n,
  input  logic [NB-1:0]     lane_n,
  input  logic              out_en_n,
  input  logic              order_lin,
  input  logic              flow_thru,
  input  logic [NB*8-1:0]   dq_i,
  output logic [NB*8-1:0]   dq_o,
  output logic              dq_drive
);
  localparam int unsigned DATA_W = NB * 8;

  cyc_e              cyc;
  logic              is_wr;
  logic [NB-1:0]     mask_now;

  logic              active_q, active_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              rd_q, rd_d;
  logic              wr_q, wr_d;
  logic [NB-1:0]     fmask_q, fmask_d;
  logic              rd_pipe_q;
  logic [DATA_W-1:0] dout_q;
  logic              dout_en;

  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic [NB-1:0]     lane_we;

  sbs_decode #(.NB(NB)) u_decode (
    .ps_strobe_n (ps_strobe_n),
    .cs_strobe_n (cs_strobe_n),
    .advance_n   (advance_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .wr_all_n    (wr_all_n),
    .wr_bytes_n  (wr_bytes_n),
    .lane_n      (lane_n),
    .active      (active_q),
    .cyc         (cyc),
    .is_wr       (is_wr),
    .mask        (mask_now)
  );

  sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .base      (base_q),
    .beat      (beat_q),
    .order_lin (order_lin),
    .addr      (cur_addr)
  );

  // Byte enables: with the address in flow-through mode, with the data otherwise
  assign lane_we = flow_thru ? fmask_q : mask_now;

  sbs_array #(.ADDR_W(ADDR_W), .NB(NB), .LANE_W(8)) u_array (
    .clk     (clk),
    .we      (wr_q),
    .lane_we (lane_we),
    .addr    (cur_addr),
    .wdata   (dq_i),
    .rdata   (mem_rdata)
  );

  // Next-state logic
  always_comb begin
    active_d = active_q;
    base_d   = base_q;
    beat_d   = beat_q;
    rd_d     = 1'b0;
    wr_d     = 1'b0;
    fmask_d  = fmask_q;
    unique case (cyc)
      CYC_DESEL: begin
        active_d = 1'b0;
      end
      CYC_START_RD: begin
        active_d = 1'b1;
        base_d   = addr_i;
        beat_d   = '0;
        rd_d     = 1'b1;
      end
      CYC_START_EX: begin
        active_d = 1'b1;
        base_d   = addr_i;
        beat_d   = '0;
        rd_d     = !is_wr;
        wr_d     = is_wr;
      end
      CYC_NEXT: begin
        beat_d = beat_q + 1'b1;
        rd_d   = !is_wr;
        wr_d   = is_wr;
      end
      CYC_HOLD: begin
        rd_d = !is_wr;
        wr_d = is_wr;
      end
      default: begin
      end
    endcase
    if (wr_d) begin
      fmask_d = mask_now;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      beat_q    <= '0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      fmask_q   <= '0;
      rd_pipe_q <= 1'b0;
    end else begin
      active_q  <= active_d;
      base_q    <= base_d;
      beat_q    <= beat_d;
      rd_q      <= rd_d;
      wr_q      <= wr_d;
      fmask_q   <= fmask_d;
      rd_pipe_q <= rd_q;
    end
  end

  // Output data register, loaded only when a read slot completes
  assign dout_en = rd_q;

  always_ff @(posedge clk) begin
    if (dout_en) begin
      dout_q <= mem_rdata;
    end
  end

  assign dq_o     = flow_thru ? mem_rdata : dout_q;
  assign dq_drive = !out_en_n && (flow_thru ? rd_q : rd_pipe_q);
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ps_strobe_n,
  input logic              cs_strobe_n,
  input logic              advance_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              rd_slot,
  input logic              wr_slot,
  input logic              active,
  input logic [ADDR_W-1:0] cur_addr
);
  // R1
  desel_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_strobe_n && sel_a_n) |=> (!rd_slot && !wr_slot && !active));

  // R2
  desel_secondary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a_n && (!ps_strobe_n || !cs_strobe_n) && (sel_c_n || !sel_b))
      |=> (!rd_slot && !wr_slot));

  // R3
  ps_start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a_n && sel_b && !sel_c_n && !ps_strobe_n)
      |=> (rd_slot && !wr_slot && cur_addr == $past(addr_i)));

  // R7
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ps_strobe_n && cs_strobe_n && advance_n) |=> $stable(cur_addr));

  // R6
  next_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ps_strobe_n && cs_strobe_n && !advance_n)
      |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));
endmodule

bind sync_burst_sram sbs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_i      (addr_i),
  .ps_strobe_n (ps_strobe_n),
  .cs_strobe_n (cs_strobe_n),
  .advance_n   (advance_n),
  .sel_a_n     (sel_a_n),
  .sel_b       (sel_b),
  .sel_c_n     (sel_c_n),
  .rd_slot     (rd_q),
  .wr_slot     (wr_q),
  .active      (active_q),
  .cur_addr    (cur_addr)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  localparam int unsigned AW = 6;
  localparam int unsigned NB = 4;
  localparam int unsigned DEPTH = 1 << AW;

  typedef struct packed {
    logic          flow;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic          gc;   // whole-word write in the address cycle
    logic          bc;   // byte-write enable in the address cycle
    logic [3:0]    lc;   // lane selects in the address cycle
    logic          gd;   // same three in the data cycle
    logic          bd;
    logic [3:0]    ld;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 6'd5,  32'h11223344, 1'b0, 1'b1, 4'h5, 1'b0, 1'b0, 4'hA}, // R9 pipelined
    '{1'b1, 6'd6,  32'h55667788, 1'b0, 1'b0, 4'hF, 1'b1, 1'b1, 4'hF}, // R9 flow
    '{1'b0, 6'd7,  32'hAABBCCDD, 1'b1, 1'b0, 4'hE, 1'b1, 1'b0, 4'hE}, // R10 byte 0
    '{1'b0, 6'd8,  32'h99887766, 1'b1, 1'b0, 4'h6, 1'b1, 1'b0, 4'h6}, // R10 bytes 0,3
    '{1'b1, 6'd9,  32'h0F0F0F0F, 1'b1, 1'b0, 4'h7, 1'b1, 1'b1, 4'hF}, // R10 byte 3 flow
    '{1'b0, 6'd10, 32'hDEADBEEF, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 4'hD}, // R11 pipe: data lanes
    '{1'b1, 6'd11, 32'hCAFEF00D, 1'b1, 1'b0, 4'hB, 1'b1, 1'b0, 4'h0}, // R11 flow: addr lanes
    '{1'b0, 6'd12, 32'h12345678, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 4'hF}, // R11 pipe: GW at data
    '{1'b1, 6'd13, 32'h87654321, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 4'hF}, // R11 flow: none
    '{1'b0, 6'd14, 32'hFFFF0000, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0}, // R4 not a write
    '{1'b1, 6'd63, 32'h01020304, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0}, // R9 last word
    '{1'b0, 6'd0,  32'hA5A55A5A, 1'b1, 1'b0, 4'h9, 1'b1, 1'b0, 4'h9}  // R10 bytes 1,2
  };

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          ps_strobe_n, cs_strobe_n, advance_n;
  logic          sel_a_n, sel_b, sel_c_n;
  logic          wr_all_n, wr_bytes_n;
  logic [NB-1:0] lane_n;
  logic          out_en_n, order_lin, flow_thru;
  logic [31:0]   dq_i, dq_o;
  logic          dq_drive;

  logic [31:0]   model [DEPTH];
  int            n_chk;
  int            n_bad;

  sync_burst_sram #(.ADDR_W(AW), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .ps_strobe_n(ps_strobe_n), .cs_strobe_n(cs_strobe_n), .advance_n(advance_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n), .lane_n(lane_n),
    .out_en_n(out_en_n), .order_lin(order_lin), .flow_thru(flow_thru),
    .dq_i(dq_i), .dq_o(dq_o), .dq_drive(dq_drive)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] lanes(input logic g, input logic b, input logic [3:0] l);
    if (!g) return 4'hF;
    if (!b) return ~l;
    return 4'h0;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] m);
    logic [31:0] r;
    r = old;
    for (int n = 0; n < 4; n++) if (m[n]) r[n*8 +: 8] = nw[n*8 +: 8];
    return r;
  endfunction

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dq_drive=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dq_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ps_strobe_n = 1'b1; cs_strobe_n = 1'b1; advance_n = 1'b1;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_all_n = 1'b1; wr_bytes_n = 1'b1; lane_n = 4'hF; out_en_n = 1'b1;
  endtask

  task automatic desel();
    idle();
    cs_strobe_n = 1'b0; sel_a_n = 1'b1;
  endtask

  // Controller-started access, then a deselect cycle carrying the write data
  task automatic write_op(input logic flow, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic gc, input logic bc, input logic [3:0] lc,
                          input logic gd, input logic bd, input logic [3:0] ld);
    logic [3:0] m;
    @(negedge clk);
    idle(); flow_thru = flow; addr_i = a; cs_strobe_n = 1'b0;
    wr_all_n = gc; wr_bytes_n = bc; lane_n = lc;
    @(negedge clk);
    desel(); dq_i = d; wr_all_n = gd; wr_bytes_n = bd; lane_n = ld;
    @(negedge clk);
    idle();
    m = flow ? lanes(gc, bc, lc) : lanes(gd, bd, ld);
    if (!gc || !bc) model[a] = merge(model[a], d, m);
  endtask

  // Processor-started read, checked at the latency of the selected mode
  task automatic read_chk(input string tag, input logic flow, input logic [AW-1:0] a);
    @(negedge clk);
    idle(); flow_thru = flow; addr_i = a; ps_strobe_n = 1'b0; out_en_n = 1'b0;
    @(negedge clk);
    if (flow) begin
      chk_bit(tag, dq_drive, 1'b1);
      chk_word(tag, dq_o, model[a]);
    end else begin
      chk_bit(tag, dq_drive, 1'b0);
    end
    desel(); out_en_n = 1'b0;
    @(negedge clk);
    if (!flow) begin
      chk_bit(tag, dq_drive, 1'b1);
      chk_word(tag, dq_o, model[a]);
    end else begin
      chk_bit(tag, dq_drive, 1'b0);
    end
    idle();
  endtask

  // Four-beat burst, a hold beat, then a deselect (R6, R7, R12)
  task automatic burst(input logic flow, input logic lin, input logic [AW-1:0] base);
    logic [AW-1:0] e [5];
    for (int j = 0; j < 5; j++) begin
      logic [1:0] k;
      k = (j < 4) ? 2'(j) : 2'd3;
      e[j] = {base[AW-1:2], lin ? (base[1:0] + k) : (base[1:0] ^ k)};
    end
    @(negedge clk);
    for (int j = 0; j < 6; j++) begin
      idle(); flow_thru = flow; order_lin = lin; out_en_n = 1'b0;
      if (j == 0) begin
        addr_i = base; cs_strobe_n = 1'b0;
      end else if (j < 4) begin
        advance_n = 1'b0;
      end else if (j == 5) begin
        cs_strobe_n = 1'b0; sel_a_n = 1'b1;
      end
      @(negedge clk);
      if (flow) begin
        if (j < 5) begin
          chk_bit("R12 flow burst", dq_drive, 1'b1);
          chk_word(j == 4 ? "R7 hold" : "R6 burst order", dq_o, model[e[j]]);
        end else begin
          chk_bit("R1 burst end", dq_drive, 1'b0);
        end
      end else begin
        if (j == 0) begin
          chk_bit("R12 pipe first", dq_drive, 1'b0);
        end else begin
          chk_bit("R12 pipe burst", dq_drive, 1'b1);
          chk_word(j == 5 ? "R7 hold" : "R6 burst order", dq_o, model[e[j-1]]);
        end
      end
    end
    idle();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; idle(); addr_i = '0; dq_i = '0; order_lin = 1'b1; flow_thru = 1'b1;
    repeat (3) @(negedge clk);
    chk_bit("R13 reset drive", dq_drive, 1'b0);
    rst_n = 1'b1;
    // R13: advance straight after reset drives nothing
    advance_n = 1'b0; out_en_n = 1'b0;
    @(negedge clk);
    chk_bit("R13 advance after reset", dq_drive, 1'b0);
    idle();

    // Preload every word with whole-word writes (R9)
    for (int a = 0; a < int'(DEPTH); a++) begin
      write_op(1'b1, AW'(a), {8'(a), 8'hA5, 8'(~a), 8'h3C}, 1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 4'hF);
    end
    read_chk("R9 preload", 1'b1, 6'd33);

    // Vector table: write then read back in the same mode (R4, R9, R10, R11, R12)
    for (int v = 0; v < 12; v++) begin
      write_op(VECS[v].flow, VECS[v].addr, VECS[v].data, VECS[v].gc, VECS[v].bc, VECS[v].lc,
               VECS[v].gd, VECS[v].bd, VECS[v].ld);
      read_chk("R10 R11 table readback", VECS[v].flow, VECS[v].addr);
    end

    // R6 R7 R12: burst orders, both modes
    burst(1'b1, 1'b0, 6'd22);
    burst(1'b1, 1'b1, 6'd23);
    burst(1'b0, 1'b0, 6'd41);
    burst(1'b0, 1'b1, 6'd42);
    burst(1'b1, 1'b1, 6'd16);

    // R3: processor strobe with write controls asserted still reads, no write
    @(negedge clk);
    idle(); flow_thru = 1'b1; addr_i = 6'd20; ps_strobe_n = 1'b0;
    wr_all_n = 1'b0; out_en_n = 1'b0;
    @(negedge clk);
    chk_bit("R3 read despite write ctl", dq_drive, 1'b1);
    chk_word("R3 read data", dq_o, model[20]);
    desel(); dq_i = 32'h0BAD0BAD; wr_all_n = 1'b0;
    @(negedge clk);
    idle();
    read_chk("R3 no write", 1'b1, 6'd20);

    // R5: primary select negated, processor strobe ignored, advance continues
    @(negedge clk);
    idle(); flow_thru = 1'b1; order_lin = 1'b1; addr_i = 6'd24; cs_strobe_n = 1'b0; out_en_n = 1'b0;
    @(negedge clk);
    chk_word("R5 start", dq_o, model[24]);
    sel_a_n = 1'b1; ps_strobe_n = 1'b0; cs_strobe_n = 1'b1; advance_n = 1'b0;
    @(negedge clk);
    chk_bit("R5 continue drive", dq_drive, 1'b1);
    chk_word("R5 continue data", dq_o, model[25]);
    // R1: controller strobe with primary select negated deselects
    advance_n = 1'b1; cs_strobe_n = 1'b0; ps_strobe_n = 1'b0;
    @(negedge clk);
    chk_bit("R1 deselect", dq_drive, 1'b0);
    idle(); advance_n = 1'b0; out_en_n = 1'b0;
    @(negedge clk);
    chk_bit("R1 burst ended", dq_drive, 1'b0);
    idle();

    // R2: bad secondary selects
    @(negedge clk);
    idle(); flow_thru = 1'b1; addr_i = 6'd30; ps_strobe_n = 1'b0; sel_b = 1'b0; out_en_n = 1'b0;
    @(negedge clk);
    chk_bit("R2 sel_b low", dq_drive, 1'b0);
    idle(); addr_i = 6'd30; ps_strobe_n = 1'b0; sel_c_n = 1'b1; out_en_n = 1'b0;
    @(negedge clk);
    chk_bit("R2 sel_c high", dq_drive, 1'b0);
    idle(); addr_i = 6'd30; cs_strobe_n = 1'b0; sel_c_n = 1'b1; wr_all_n = 1'b0;
    @(negedge clk);
    desel(); dq_i = 32'h5EE5EE55; wr_all_n = 1'b0;
    @(negedge clk);
    idle();
    read_chk("R2 no write", 1'b1, 6'd30);

    // R8: output enable gates the drive within the cycle
    @(negedge clk);
    idle(); flow_thru = 1'b1; addr_i = 6'd35; ps_strobe_n = 1'b0; out_en_n = 1'b1;
    @(negedge clk);
    chk_bit("R8 oe high", dq_drive, 1'b0);
    desel(); out_en_n = 1'b0;
    #1;
    chk_bit("R8 oe low same cycle", dq_drive, 1'b1);
    chk_word("R8 data", dq_o, model[35]);
    @(negedge clk);
    idle();

    // R4: controller-started write then pipelined readback
    write_op(1'b0, 6'd50, 32'h76543210, 1'b0, 1'b1, 4'hF, 1'b0, 1'b1, 4'hF);
    read_chk("R4 write", 1'b0, 6'd50);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule